// File: doc/BRIEF.md
# Byte/Word ALU With Status Flags

This block performs one arithmetic or logic operation per clock on two operands. The operands are treated as either 8 bits or 16 bits wide, chosen by a width-select input on each operation. The supported operations are add, subtract, compare, increment and exclusive-or. The result goes into a result register, and a one-cycle write-enable pulse goes with it. The same clock edge updates a status register holding carry, parity, auxiliary-carry, zero, sign and overflow flags. Compare computes a subtraction only for its flags and raises no write enable.

Three control bits sit beside the arithmetic flags: direction, interrupt-enable and trap. Separate set and clear inputs write them. Those writes never interact with the operation that runs in the same cycle.

All outputs are registered. An operation presented with `op_valid` high before a rising edge appears on the outputs just after that edge.

Top module: `bw_alu`

## Requirements
- R1: ADD (op code 0) yields the sum at the selected width (`wide`=1 for 16 bits, 0 for 8 bits). CF is 1 exactly when the unsigned sum exceeds the width, for example 0xFF+0x01 in byte mode gives result 0x00 with CF=1.
- R2: SUB (op code 1) yields a minus b at the selected width. CF is 1 exactly when b is greater than a as unsigned values (a borrow).
- R3: AF is 1 when an add carries out of bit 3, or when a subtract needs a borrow into bit 3, judged on the low nibbles of the operands.
- R4: OF is 1 exactly when the signed result falls outside the signed range of the selected width. For example, 100+50 in byte mode sets OF.
- R5: ZF is 1 exactly when the result at the selected width is zero. SF equals the result's top bit at the selected width (bit 7 or bit 15).
- R6: PF is 1 when bits 7..0 of the result hold an even number of ones, and 0 otherwise. Bits above 7 are ignored, in word mode as well.
- R7: CMP (op code 2) sets all six arithmetic flags exactly as SUB would. It keeps `result_we` low and leaves `result` unchanged.
- R8: INC (op code 3) yields a+1 at the selected width and sets AF, OF, ZF, SF and PF as for an add of 1. CF keeps its previous value.
- R9: XOR (op code 4) yields a^b at the selected width, with ZF, SF and PF from the result. CF, OF and AF become 0, and a^a gives result 0 with ZF=1.
- R10: For each bit i of `ctl_flags` (bit 0 direction, bit 1 interrupt-enable, bit 2 trap), `ctl_set[i]` writes 1 and otherwise `ctl_clr[i]` writes 0, effective after the next edge. Set wins over clear, and these writes are independent of any operation in the same cycle.
- R11: When `op_valid` is low, or the op code is 5, 6 or 7, `result` and all six arithmetic flags hold their values and `result_we` is 0.
- R12: While `rst_n` is low, `result` is 0, `result_we` is 0, and all arithmetic and control flags are 0.
- R13: In byte mode, bits 15..8 of `result` are 0 after any writing operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | 0 ADD, 1 SUB, 2 CMP, 3 INC, 4 XOR, 5..7 no operation |
| wide | input | 1 | 1 = 16-bit operands, 0 = 8-bit operands |
| opnd_a | input | 16 | First operand (minuend for SUB/CMP, increment source for INC) |
| opnd_b | input | 16 | Second operand (unused by INC) |
| ctl_set | input | 3 | Per-bit set of the control flags |
| ctl_clr | input | 3 | Per-bit clear of the control flags |
| result | output | 16 | Registered result |
| result_we | output | 1 | One-cycle write-back enable for `result` |
| cf | output | 1 | Carry / borrow flag |
| pf | output | 1 | Even parity of result bits 7..0 |
| af | output | 1 | Low-nibble carry / borrow flag |
| zf | output | 1 | Zero flag |
| sf | output | 1 | Sign flag |
| of | output | 1 | Signed overflow flag |
| ctl_flags | output | 3 | Direction, interrupt-enable, trap bits |

## Verification
Two things can land on the same clock edge: an arithmetic flag update and a control-bit write. The two also sit next to each other in the status state. The bench drives set and clear pulses, including both at once on one bit, in cycles that also carry INC, XOR and CMP. This is where a carry kept from before or a cleared overflow bit could be disturbed. After every edge the bench compares the control bits and the six arithmetic flags against its own model, so a write that leaks from one group into the other shows up in that same cycle.

// File: rtl/bw_alu.sv
module bw_alu #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [2:0]   op_code,
  input  logic         wide,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [2:0]   ctl_set,
  input  logic [2:0]   ctl_clr,
  output logic [W-1:0] result,
  output logic         result_we,
  output logic         cf,
  output logic         pf,
  output logic         af,
  output logic         zf,
  output logic         sf,
  output logic         of,
  output logic [2:0]   ctl_flags
);
  localparam int H = W / 2;
  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_CMP = 3'd2;
  localparam logic [2:0] OP_INC = 3'd3;
  localparam logic [2:0] OP_XOR = 3'd4;

  logic [W-1:0] mask, x, y, r;
  logic [W:0]   full;
  logic         is_sub, is_xor, known;
  logic         c_n, a_n, o_n, xs, ys, rs;

  assign mask   = wide ? {W{1'b1}} : {{(W-H){1'b0}}, {H{1'b1}}};
  assign is_sub = (op_code == OP_SUB) || (op_code == OP_CMP);
  assign is_xor = (op_code == OP_XOR);
  assign known  = (op_code <= OP_XOR);
  assign x      = opnd_a & mask;
  assign y      = (op_code == OP_INC) ? {{(W-1){1'b0}}, 1'b1} : (opnd_b & mask);
  assign full   = is_sub ? ({1'b0, x} - {1'b0, y}) : ({1'b0, x} + {1'b0, y});
  assign r      = is_xor ? (x ^ y) : (full[W-1:0] & mask);

  assign xs  = wide ? x[W-1] : x[H-1];
  assign ys  = wide ? y[W-1] : y[H-1];
  assign rs  = wide ? r[W-1] : r[H-1];
  assign c_n = wide ? full[W] : full[H];
  assign a_n = x[4] ^ y[4] ^ r[4];
  assign o_n = is_sub ? ((xs != ys) && (rs != xs)) : ((xs == ys) && (rs != xs));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result    <= '0;
      result_we <= 1'b0;
      {cf, pf, af, zf, sf, of} <= 6'b0;
    end else begin
      result_we <= 1'b0;
      if (op_valid && known) begin
        pf <= ~^r[7:0];
        zf <= (r == '0);
        sf <= rs;
        if (is_xor) begin
          cf <= 1'b0;
          af <= 1'b0;
          of <= 1'b0;
        end else begin
          af <= a_n;
          of <= o_n;
          if (op_code != OP_INC) cf <= c_n;
        end
        if (op_code != OP_CMP) begin
          result    <= r;
          result_we <= 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < 3; i++) begin : g_ctl
    always_ff @(posedge clk) begin
      if (!rst_n)          ctl_flags[i] <= 1'b0;
      else if (ctl_set[i]) ctl_flags[i] <= 1'b1;
      else if (ctl_clr[i]) ctl_flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/bw_alu_chk.sv
module bw_alu_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic [2:0]   op_code,
  input logic [2:0]   ctl_set,
  input logic [W-1:0] result,
  input logic         result_we,
  input logic         cf,
  input logic         pf,
  input logic         af,
  input logic         zf,
  input logic         sf,
  input logic         of,
  input logic [2:0]   ctl_flags
);
  // R7
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd2) |=> (!result_we && $stable(result)));

  // R8
  inc_carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd3) |=> (cf == $past(cf)));

  // R9
  xor_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd4) |=> (!cf && !of && !af));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid) |=> (!result_we && $stable(result) && $stable({cf, pf, af, zf, sf, of})));

  // R5
  zero_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_we |-> (zf == (result == '0)));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_set != 3'b0) |=> ((ctl_flags & $past(ctl_set)) == $past(ctl_set)));
endmodule

bind bw_alu bw_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .ctl_set(ctl_set), .result(result), .result_we(result_we),
  .cf(cf), .pf(pf), .af(af), .zf(zf), .sf(sf), .of(of), .ctl_flags(ctl_flags)
);

// File: tb/test_bw_alu.sv
module test_bw_alu;
  logic        clk = 0, rst_n = 0, op_valid = 0, wide = 0;
  logic [2:0]  op_code = 0, ctl_set = 0, ctl_clr = 0;
  logic [15:0] opnd_a = 0, opnd_b = 0;
  logic [15:0] result;
  logic        result_we, cf, pf, af, zf, sf, of;
  logic [2:0]  ctl_flags;

  int n_chk = 0, n_err = 0;
  int m_res = 0, m_we = 0, m_cf = 0, m_pf = 0, m_af = 0, m_zf = 0, m_sf = 0, m_of = 0;
  int m_ctl[3] = '{0, 0, 0};

  always #5 clk = ~clk;

  bw_alu i_bw_alu (.*);

  initial begin
    #2000000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int sx(int v, int bits);
    return (v >= (1 << (bits - 1))) ? v - (1 << bits) : v;
  endfunction

  task automatic model(bit v, int op, bit w, int a, int b, int s, int c);
    int m, bits, x, y, r, sr;
    bits = w ? 16 : 8;
    m = (1 << bits) - 1;
    x = a & m;
    y = (op == 3) ? 1 : (b & m);
    m_we = 0;
    if (v && op <= 4) begin
      if (op == 4) begin
        r = x ^ y; m_cf = 0; m_af = 0; m_of = 0;
      end else if (op == 1 || op == 2) begin
        r = (x - y) & m;
        m_cf = (x < y);
        m_af = ((x & 15) < (y & 15));
        sr = sx(x, bits) - sx(y, bits);
        m_of = (sr < -(1 << (bits - 1))) || (sr > (1 << (bits - 1)) - 1);
      end else begin
        r = (x + y) & m;
        if (op == 0) m_cf = ((x + y) > m);
        m_af = (((x & 15) + (y & 15)) > 15);
        sr = sx(x, bits) + sx(y, bits);
        m_of = (sr < -(1 << (bits - 1))) || (sr > (1 << (bits - 1)) - 1);
      end
      m_zf = (r == 0);
      m_sf = (r >> (bits - 1)) & 1;
      m_pf = ($countones(r & 255) % 2 == 0);
      if (op != 2) begin m_res = r; m_we = 1; end
    end
    for (int i = 0; i < 3; i++)
      if ((s >> i) & 1) m_ctl[i] = 1;
      else if ((c >> i) & 1) m_ctl[i] = 0;
  endtask

  task automatic step(bit v, int op, bit w, int a, int b, int s = 0, int c = 0);
    string t;
    @(negedge clk);
    op_valid = v; op_code = op[2:0]; wide = w;
    opnd_a = a[15:0]; opnd_b = b[15:0]; ctl_set = s[2:0]; ctl_clr = c[2:0];
    @(posedge clk); #1;
    model(v, op, w, a, b, s, c);
    case (op)
      0: t = "R1"; 1: t = "R2"; 2: t = "R7"; 3: t = "R8"; 4: t = "R9";
      default: t = "R11";
    endcase
    if (!v) t = "R11";
    if (!w && v && op <= 4) t = {t, " R13"};
    chk({t, " result"}, result, m_res);
    chk({t, " result_we"}, result_we, m_we);
    chk({t, " cf"}, cf, m_cf);
    chk("R3 af", af, m_af);
    chk("R4 of", of, m_of);
    chk("R5 zf", zf, m_zf);
    chk("R5 sf", sf, m_sf);
    chk("R6 pf", pf, m_pf);
    chk("R10 ctl_flags", ctl_flags, m_ctl[0] | (m_ctl[1] << 1) | (m_ctl[2] << 2));
  endtask

  initial begin
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk("R12 result", result, 0);
    chk("R12 result_we", result_we, 0);
    chk("R12 flags", {cf, pf, af, zf, sf, of}, 0);
    chk("R12 ctl_flags", ctl_flags, 0);
    @(negedge clk); rst_n = 1;

    step(1, 0, 0, 'hFF, 'h01);          // R1 byte carry, R3 af
    step(1, 0, 0, 100, 50);             // R4 signed overflow byte
    step(1, 0, 1, 'h7FFF, 1);           // R4 word
    step(1, 0, 1, 'hFFFF, 'h0001);      // R1 word carry
    step(1, 0, 1, 'h0180, 'h0001);      // R6 parity low byte only
    step(1, 1, 0, 'h10, 'h01);          // R2 nibble borrow
    step(1, 1, 1, 0, 1);                // R2 borrow word
    step(1, 1, 0, 'h80, 'h01);          // R4 sub overflow
    step(1, 2, 1, 'h1234, 'h1234);      // R7 compare equal
    step(1, 2, 0, 'h01, 'h02);          // R7 result held
    step(1, 3, 0, 'hFF, 0, 3'b001, 0);  // R8 carry kept while R10 sets
    step(1, 0, 0, 1, 1);
    step(1, 3, 1, 'h7FFF, 0, 0, 3'b001);// R8 carry kept, overflow
    step(1, 4, 1, 'hA5A5, 'hA5A5, 3'b110, 3'b110); // R9 self-clear, R10 set wins
    step(1, 4, 0, 'h3C, 'hC3, 0, 3'b010);
    step(1, 5, 1, 1, 1);                // R11 unused code
    step(1, 7, 0, 'hFF, 'hFF, 0, 3'b111);
    step(0, 0, 1, 'hFFFF, 'hFFFF);      // R11 idle
    for (int k = 0; k < 600; k++)
      step($urandom_range(0, 7) != 0, $urandom_range(0, 7), $urandom_range(0, 1),
           $urandom_range(0, 65535), $urandom_range(0, 65535),
           $urandom_range(0, 7) & $urandom_range(0, 7), $urandom_range(0, 7));
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule